// File: doc/BRIEF.md
# Two-Slot Statically Scheduled Datapath with Split Register Files

This block is a small statically scheduled datapath with two issue slots. One slot holds an arithmetic/logic unit that also drives a small data memory. The other slot holds a signed multiply-accumulate unit with a double-width accumulator. Each slot reads its two operands from two private register files of eight entries each. There are four files in total, and each has one read port and one write port.

The units place their results on two shared result buses. The ALU slot drives `bus_a`, which carries the ALU result or the data read from memory. The MAC slot drives `bus_m`, which carries an accumulator half. Each register file takes its write data through an input multiplexer that picks one of the two buses. The select bits for these multiplexers are fields of the instruction word, so the routing can change on every cycle.

A program counter steps through a small instruction array, one word per cycle, while `run` is high. The instruction array and the data memory are filled through their own write ports while `run` is low. Unit flags are brought out on `flags`.

Top module: `dual_slot_vliw`

## Requirements
- R1: After reset, `pc` is 0, all four flag bits are 0, the accumulator is 0 and every register file entry reads 0.
- R2: While `run` is high, `pc` advances by one per clock and wraps from 31 to 0. While `run` is low, `pc` holds and no register file, accumulator, memory or flag changes.
- R3: The 20-bit instruction word is laid out as follows, from bit 19 down. Bit 19 is the ALU-side bus select and bit 18 is the MAC-side bus select. Bits 17:15 address file 1, bits 14:12 file 2, bits 11:9 hold the ALU opcode, bits 8:6 address file 3, bits 5:3 file 4, and bits 2:0 hold the MAC opcode. Each file field is used as both the read address and the write address of that file.
- R4: The ALU opcodes are 0 NOP, 1 ADD (f1+f2), 2 SUB (f1-f2), 3 AND, 4 OR, 5 PASS (f2), 6 LOAD and 7 STORE. For codes 1 to 5, `bus_a` shows the 16-bit result and the ALU-side multiplexer output is written to file 1.
- R5: A bus select bit of 0 routes `bus_a` into that side's files, and a value of 1 routes `bus_m`.
- R6: A register write takes effect at the clock edge. A read of the same entry in the same cycle returns the old value.
- R7: The memory is 16 words deep. The address is the low 4 bits of the file 1 operand. LOAD puts the stored word on `bus_a` and writes the ALU-side multiplexer output to file 2. STORE writes the file 2 operand to memory and shows 0 on `bus_a`.
- R8: The MAC opcodes are 0 NOP, 1 CLR (accumulator becomes 0), 2 MAC (accumulator plus the signed product f3*f4, modulo 2^32), 3 RDHI and 4 RDLO. Codes 5 to 7 act as NOP. RDHI shows accumulator bits 31:16 on `bus_m` and writes the MAC-side multiplexer output to file 3. RDLO shows bits 15:0 and writes to file 4. Every other code shows 0 on `bus_m`.
- R9: The flags are laid out as follows. Bit 0 is the ALU zero flag and bit 1 the ALU negative flag; both are updated only by ALU codes 1 to 5. Bit 2 is the accumulator sign. Bit 3 is set when the last LOAD returned 0. All flags reflect the previous executed instruction.
- R10: A NOP in a slot leaves that slot's register files, its flags and the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Execute and advance the program counter |
| prog_we | input | 1 | Instruction array write strobe |
| prog_addr | input | 5 | Instruction array write index |
| prog_word | input | 20 | Instruction word to store |
| dpre_we | input | 1 | Data memory preload strobe (use with run low) |
| dpre_addr | input | 4 | Data memory preload index |
| dpre_data | input | 16 | Data memory preload word |
| pc | output | 5 | Current program counter |
| bus_a | output | 16 | ALU-slot result bus |
| bus_m | output | 16 | MAC-slot result bus |
| flags | output | 4 | {load zero, accumulator sign, ALU negative, ALU zero} |

## Verification
The result buses are combinational from the instruction at `pc`, so they are due in the same cycle as that instruction. The register file, accumulator, memory and flag effects of that instruction become visible one edge later. The bench therefore samples at the falling edge. At that point it compares both buses with a model evaluated on the pre-edge state, and it compares `flags` with the model state left by the previous instruction. Only after those comparisons does it advance its model, and it does so only for cycles whose rising edge sees `run` high.

// File: rtl/dsv_pkg.sv
package dsv_pkg;
  localparam logic [2:0] AOP_NOP   = 3'd0;
  localparam logic [2:0] AOP_ADD   = 3'd1;
  localparam logic [2:0] AOP_SUB   = 3'd2;
  localparam logic [2:0] AOP_AND   = 3'd3;
  localparam logic [2:0] AOP_OR    = 3'd4;
  localparam logic [2:0] AOP_PASS  = 3'd5;
  localparam logic [2:0] AOP_LOAD  = 3'd6;
  localparam logic [2:0] AOP_STORE = 3'd7;

  localparam logic [2:0] MOP_NOP  = 3'd0;
  localparam logic [2:0] MOP_CLR  = 3'd1;
  localparam logic [2:0] MOP_MAC  = 3'd2;
  localparam logic [2:0] MOP_RDHI = 3'd3;
  localparam logic [2:0] MOP_RDLO = 3'd4;

  localparam int NUM_RF = 4;
  localparam int OPC_W  = 3;

  // ALU codes that produce a result for file 1 and update the ALU flags
  function automatic logic alu_is_arith(input logic [2:0] op);
    return (op >= AOP_ADD) && (op <= AOP_PASS);
  endfunction
endpackage

// File: rtl/dsv_rf_bank.sv
module dsv_rf_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ent_q [DEPTH];
  logic [DW-1:0] ent_d [DEPTH];

  always_comb begin
    ent_d = ent_q;
    if (we) ent_d[addr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      ent_q <= ent_d;
    end
  end

  // read sees the stored value; a same-cycle write lands at the edge
  assign rdata = ent_q[addr];
endmodule

// File: rtl/dsv_alu_slot.sv
module dsv_alu_slot
  import dsv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] result,
  output logic          zero_q,
  output logic          neg_q
);
  logic zero_d, neg_d, flag_en;

  always_comb begin
    case (op)
      AOP_ADD:  result = opa + opb;
      AOP_SUB:  result = opa - opb;
      AOP_AND:  result = opa & opb;
      AOP_OR:   result = opa | opb;
      AOP_PASS: result = opb;
      default:  result = '0;
    endcase
  end

  assign flag_en = en && alu_is_arith(op);

  always_comb begin
    zero_d = zero_q;
    neg_d  = neg_q;
    if (flag_en) begin
      zero_d = (result == '0);
      neg_d  = result[DW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      zero_q <= zero_d;
      neg_q  <= neg_d;
    end
  end
endmodule

// File: rtl/dsv_mac_slot.sv
module dsv_mac_slot
  import dsv_pkg::*;
#(
  parameter int DW  = 16,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] bus_out,
  output logic [AW-1:0] acc_q
);
  logic signed [AW-1:0] prod;
  logic [AW-1:0]        acc_d;

  assign prod = $signed(opa) * $signed(opb);

  always_comb begin
    acc_d = acc_q;
    if (en) begin
      case (op)
        MOP_CLR: acc_d = '0;
        MOP_MAC: acc_d = acc_q + prod;
        default: acc_d = acc_q;
      endcase
    end
  end

  always_comb begin
    case (op)
      MOP_RDHI: bus_out = acc_q[AW-1:DW];
      MOP_RDLO: bus_out = acc_q[DW-1:0];
      default:  bus_out = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/dsv_dmem.sv
module dsv_dmem #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_data,
  input  logic          st_en,
  input  logic          ld_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ldz_q
);
  logic [DW-1:0] word_q [DEPTH];
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          ldz_d;

  // preload has priority over a store
  always_comb begin
    wr_en   = pre_we || st_en;
    wr_addr = pre_we ? pre_addr : addr;
    wr_data = pre_we ? pre_data : wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_addr] <= wr_data;
  end

  assign rdata = word_q[addr];

  always_comb begin
    ldz_d = ldz_q;
    if (ld_en) ldz_d = (rdata == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldz_q <= 1'b0;
    else        ldz_q <= ldz_d;
  end
endmodule

// File: rtl/dual_slot_vliw.sv
module dual_slot_vliw
  import dsv_pkg::*;
#(
  parameter int DW        = 16,
  parameter int RF_AW     = 3,
  parameter int IMEM_AW   = 5,
  parameter int DMEM_AW   = 4,
  localparam int IW       = 2 + 4 * RF_AW + 2 * OPC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [IW-1:0]      prog_word,
  input  logic               dpre_we,
  input  logic [DMEM_AW-1:0] dpre_addr,
  input  logic [DW-1:0]      dpre_data,
  output logic [IMEM_AW-1:0] pc,
  output logic [DW-1:0]      bus_a,
  output logic [DW-1:0]      bus_m,
  output logic [3:0]         flags
);
  localparam int RF_DEPTH   = 1 << RF_AW;
  localparam int IMEM_DEPTH = 1 << IMEM_AW;
  localparam int DMEM_DEPTH = 1 << DMEM_AW;
  localparam int ACC_W      = 2 * DW;
  // field low bits, word packed from the top down
  localparam int L_MOP = 0;
  localparam int L_F4  = L_MOP + OPC_W;
  localparam int L_F3  = L_F4 + RF_AW;
  localparam int L_AOP = L_F3 + RF_AW;
  localparam int L_F2  = L_AOP + OPC_W;
  localparam int L_F1  = L_F2 + RF_AW;
  localparam int L_SM  = L_F1 + RF_AW;
  localparam int L_SA  = L_SM + 1;

  // reset: asserted at once, released after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // instruction array and program counter
  logic [IW-1:0]      imem_q [IMEM_DEPTH];
  logic [IMEM_AW-1:0] pc_q, pc_d;
  logic [IW-1:0]      instr;

  always_ff @(posedge clk) begin
    if (prog_we) imem_q[prog_addr] <= prog_word;
  end

  always_comb begin
    pc_d = pc_q;
    if (run) pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) pc_q <= '0;
    else          pc_q <= pc_d;
  end

  assign instr = imem_q[pc_q];
  assign pc    = pc_q;

  // field decode
  logic                        sel_a_f, sel_m_f;
  logic [2:0]                  aop_f, mop_f;
  logic [NUM_RF-1:0][RF_AW-1:0] rf_addr;

  always_comb begin
    sel_a_f    = instr[L_SA];
    sel_m_f    = instr[L_SM];
    aop_f      = instr[L_AOP +: OPC_W];
    mop_f      = instr[L_MOP +: OPC_W];
    rf_addr[0] = instr[L_F1 +: RF_AW];
    rf_addr[1] = instr[L_F2 +: RF_AW];
    rf_addr[2] = instr[L_F3 +: RF_AW];
    rf_addr[3] = instr[L_F4 +: RF_AW];
  end

  // register files: one read and one write port each
  logic [NUM_RF-1:0][DW-1:0] rf_rd;
  logic [NUM_RF-1:0][DW-1:0] rf_wd;
  logic [NUM_RF-1:0]         rf_we;
  logic [DW-1:0]             mux_a, mux_m;

  assign mux_a = sel_a_f ? bus_m : bus_a;
  assign mux_m = sel_m_f ? bus_m : bus_a;

  always_comb begin
    rf_we[0] = run && alu_is_arith(aop_f);
    rf_we[1] = run && (aop_f == AOP_LOAD);
    rf_we[2] = run && (mop_f == MOP_RDHI);
    rf_we[3] = run && (mop_f == MOP_RDLO);
    rf_wd[0] = mux_a;
    rf_wd[1] = mux_a;
    rf_wd[2] = mux_m;
    rf_wd[3] = mux_m;
  end

  for (genvar g = 0; g < NUM_RF; g++) begin : g_rf
    dsv_rf_bank #(.DW(DW), .DEPTH(RF_DEPTH)) u_rf (
      .clk   (clk),
      .rst_n (rst_q_n),
      .we    (rf_we[g]),
      .addr  (rf_addr[g]),
      .wdata (rf_wd[g]),
      .rdata (rf_rd[g])
    );
  end

  // ALU slot with the data memory sharing its issue
  logic [DW-1:0] alu_res, ld_data;
  logic          alu_zero_q, alu_neg_q, ldz_q;

  dsv_alu_slot #(.DW(DW)) u_alu (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .en     (run),
    .op     (aop_f),
    .opa    (rf_rd[0]),
    .opb    (rf_rd[1]),
    .result (alu_res),
    .zero_q (alu_zero_q),
    .neg_q  (alu_neg_q)
  );

  dsv_dmem #(.DW(DW), .DEPTH(DMEM_DEPTH)) u_dmem (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .pre_we   (dpre_we),
    .pre_addr (dpre_addr),
    .pre_data (dpre_data),
    .st_en    (run && (aop_f == AOP_STORE)),
    .ld_en    (run && (aop_f == AOP_LOAD)),
    .addr     (rf_rd[0][DMEM_AW-1:0]),
    .wdata    (rf_rd[1]),
    .rdata    (ld_data),
    .ldz_q    (ldz_q)
  );

  assign bus_a = (aop_f == AOP_LOAD) ? ld_data : alu_res;

  // MAC slot
  logic [ACC_W-1:0] acc_q;

  dsv_mac_slot #(.DW(DW)) u_mac (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .en      (run),
    .op      (mop_f),
    .opa     (rf_rd[2]),
    .opb     (rf_rd[3]),
    .bus_out (bus_m),
    .acc_q   (acc_q)
  );

  assign flags = {ldz_q, acc_q[ACC_W-1], alu_neg_q, alu_zero_q};
endmodule

// File: rtl/dsv_checker.sv
module dsv_checker
  import dsv_pkg::*;
#(
  parameter int DW      = 16,
  parameter int IMEM_AW = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic [IMEM_AW-1:0] pc,
  input logic [2:0]         aop,
  input logic [2:0]         mop,
  input logic [3:0]         flags,
  input logic [DW-1:0]      bus_a,
  input logic [2*DW-1:0]    acc
);
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (pc == $past(pc) + 1'b1));

  p_pause_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(pc) && $stable(acc) && $stable(flags)));

  p_clr_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mop == MOP_CLR) |=> (acc == '0));

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && alu_is_arith(aop)) |=> (flags[0] == ($past(bus_a) == '0)));

  p_alu_nop_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (aop == AOP_NOP) |=> $stable(flags[1:0]));

  p_mac_nop_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mop == MOP_NOP) |=> $stable(acc));
endmodule

bind dual_slot_vliw dsv_checker #(.DW(DW), .IMEM_AW(IMEM_AW)) u_dsv_chk (
  .clk   (clk),
  .rst_n (rst_q_n),
  .run   (run),
  .pc    (pc),
  .aop   (aop_f),
  .mop   (mop_f),
  .flags (flags),
  .bus_a (bus_a),
  .acc   (acc_q)
);

// File: tb/tb_dual_slot_vliw.sv
module tb_dual_slot_vliw;
  logic        clk = 1'b0;
  logic        rst_n, run, prog_we, dpre_we;
  logic [4:0]  prog_addr, pc;
  logic [19:0] prog_word;
  logic [3:0]  dpre_addr, flags;
  logic [15:0] dpre_data, bus_a, bus_m;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_slot_vliw dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_word(prog_word),
    .dpre_we(dpre_we), .dpre_addr(dpre_addr), .dpre_data(dpre_data),
    .pc(pc), .bus_a(bus_a), .bus_m(bus_m), .flags(flags)
  );

  // reference state
  logic [19:0] prog   [32];
  logic [15:0] m_rf   [4][8];
  logic [15:0] m_mem  [16];
  logic [31:0] m_acc;
  logic        m_zf, m_nf, m_ldz;
  logic [4:0]  m_pc;

  // R3 word layout: sel_a, sel_m, f1, f2, alu op, f3, f4, mac op
  function automatic logic [19:0] enc(input logic sa, input logic sm,
      input logic [2:0] f1, input logic [2:0] f2, input logic [2:0] aop,
      input logic [2:0] f3, input logic [2:0] f4, input logic [2:0] mop);
    return {sa, sm, f1, f2, aop, f3, f4, mop};
  endfunction

  function automatic logic [15:0] exp_bus_a(input logic [19:0] w);
    logic [15:0] a, b;
    a = m_rf[0][w[17:15]];
    b = m_rf[1][w[14:12]];
    case (w[11:9])
      3'd1: return a + b;
      3'd2: return a - b;
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return b;
      3'd6: return m_mem[a[3:0]];
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] exp_bus_m(input logic [19:0] w);
    case (w[2:0])
      3'd3: return m_acc[31:16];
      3'd4: return m_acc[15:0];
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_exec();
    logic [19:0] w;
    logic [15:0] ba, bm, mx_a, mx_m, r1, r2, r3, r4;
    logic signed [31:0] prod;
    w  = prog[m_pc];
    r1 = m_rf[0][w[17:15]];
    r2 = m_rf[1][w[14:12]];
    r3 = m_rf[2][w[8:6]];
    r4 = m_rf[3][w[5:3]];
    ba = exp_bus_a(w);
    bm = exp_bus_m(w);
    mx_a = w[19] ? bm : ba;
    mx_m = w[18] ? bm : ba;
    prod = $signed(r3) * $signed(r4);
    if (w[11:9] >= 3'd1 && w[11:9] <= 3'd5) begin
      m_rf[0][w[17:15]] = mx_a;
      m_zf = (ba == 16'h0);
      m_nf = ba[15];
    end else if (w[11:9] == 3'd6) begin
      m_rf[1][w[14:12]] = mx_a;
      m_ldz = (ba == 16'h0);
    end else if (w[11:9] == 3'd7) begin
      m_mem[r1[3:0]] = r2;
    end
    case (w[2:0])
      3'd1: m_acc = 32'h0;
      3'd2: m_acc = m_acc + prod;
      3'd3: m_rf[2][w[8:6]] = mx_m;
      3'd4: m_rf[3][w[5:3]] = mx_m;
      default: ;
    endcase
    m_pc = m_pc + 5'd1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (pc %0d)", tag, act, exp, m_pc);
    end
  endtask

  task automatic check_all();
    logic [19:0] w;
    string ta;
    w = prog[m_pc];
    if (w[11:9] == 3'd0)      ta = "R10 bus_a";
    else if (w[11:9] >= 3'd6) ta = "R7 R5 bus_a";
    else                      ta = "R3 R4 R5 R6 bus_a";
    chk("R2 pc", {27'h0, pc}, {27'h0, m_pc});
    chk(ta, {16'h0, bus_a}, {16'h0, exp_bus_a(w)});
    chk("R8 R5 bus_m", {16'h0, bus_m}, {16'h0, exp_bus_m(w)});
    chk("R9 R10 flags", {28'h0, flags}, {28'h0, m_ldz, m_acc[31], m_nf, m_zf});
  endtask

  // drive run for n cycles, checking each cycle at the falling edge
  task automatic run_cycles(input int n, input logic r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      run = r;
      check_all();
      if (r) model_exec();
    end
  endtask

  task automatic load_prog();
    @(negedge clk);
    run = 1'b0;
    for (int i = 0; i < 32; i++) begin
      prog_we = 1'b1; prog_addr = 5'(i); prog_word = prog[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; run = 1'b0; prog_we = 1'b0; dpre_we = 1'b0;
    prog_addr = '0; prog_word = '0; dpre_addr = '0; dpre_data = '0;
    for (int k = 0; k < 4; k++)
      for (int e = 0; e < 8; e++) m_rf[k][e] = 16'h0;
    m_acc = 32'h0; m_zf = 1'b0; m_nf = 1'b0; m_ldz = 1'b0; m_pc = 5'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pc", {27'h0, pc}, 32'h0);
    chk("R1 flags", {28'h0, flags}, 32'h0);

    // data memory preload with corner values
    for (int i = 0; i < 16; i++) begin
      case (i)
        0: m_mem[i] = 16'h0003;
        2: m_mem[i] = 16'h8000;
        3: m_mem[i] = 16'hFFFB;
        5: m_mem[i] = 16'hFFFF;
        default: m_mem[i] = 16'($urandom());
      endcase
      dpre_we = 1'b1; dpre_addr = 4'(i); dpre_data = m_mem[i];
      @(negedge clk);
    end
    dpre_we = 1'b0;

    // directed program
    for (int i = 0; i < 32; i++) prog[i] = 20'h0;
    prog[0]  = enc(0,0,0,0,3'd6,0,0,3'd0);  // load mem[0] into f2[0]
    prog[1]  = enc(0,0,1,0,3'd5,0,0,3'd4);  // pass, bus_a also routed into f4
    prog[2]  = enc(0,0,1,1,3'd6,0,0,3'd3);  // load -5, bus_a routed into f3
    prog[3]  = enc(0,0,1,1,3'd1,0,0,3'd2);  // negative add, MAC -5*3
    prog[4]  = enc(0,0,2,0,3'd2,0,0,3'd0);  // 0-3
    prog[5]  = enc(0,0,3,0,3'd5,0,0,3'd0);
    prog[6]  = enc(0,0,3,0,3'd2,0,0,3'd0);  // zero result
    prog[7]  = enc(0,0,1,0,3'd7,0,0,3'd0);  // store to address 14
    prog[8]  = enc(0,0,1,2,3'd6,0,0,3'd0);  // load back
    prog[9]  = enc(1,1,0,0,3'd0,1,0,3'd3);  // ALU NOP, bus_m into f3
    prog[10] = enc(1,0,4,0,3'd1,0,1,3'd4);  // crossed routing both sides
    prog[11] = enc(0,0,4,0,3'd1,1,1,3'd2);
    prog[12] = enc(0,0,4,0,3'd1,0,0,3'd0);  // reads value written last cycle
    prog[13] = enc(0,0,4,4,3'd4,0,0,3'd0);
    prog[14] = enc(0,0,4,2,3'd3,0,0,3'd0);
    prog[15] = enc(0,0,0,7,3'd7,0,0,3'd1);  // store 0 to mem[0], clear
    prog[16] = enc(0,0,0,3,3'd6,0,0,3'd4);  // load zero
    prog[17] = enc(0,0,2,2,3'd0,2,2,3'd6);  // both slots idle
    load_prog();
    run_cycles(32, 1'b1);
    run_cycles(4, 1'b0);

    // random programs
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 32; i++) prog[i] = 20'($urandom());
      load_prog();
      run_cycles(21, 1'b1);
      run_cycles(3, 1'b0);
      run_cycles(43, 1'b1);
    end

    @(negedge clk);
    run = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule